// File: doc/BRIEF.md
# Paged RAM Disk Bus Slave

This block is a RAM disk that a processor reaches through a 512-byte window in its I/O page. Software first writes a page number into the control/status register (CSR) in the lower half of the window. It then reads or writes the 256-byte buffer in the upper half. Each buffer access goes to a slice of a large byte-parity store, and the page number chooses which slice. Switches set where the window sits in the I/O page. The block has no interrupt output.

Every byte in the store carries an odd-parity bit. The parity bit is written with the byte and checked when the byte is read. A failed check sets a sticky flag, which software reads back in the top bit of the CSR. Any CSR write clears the flag. The store contents are not reset, so locations that have never been written may fail their parity check. Software therefore clears the whole store with zero writes before using it. The model keeps a parameterised number of pages (`STORE_PG_BITS`); higher page bits alias onto them. `HALF_CAP` selects the half-capacity variant.

Top module: `paged_ramdisk`

## Requirements
- R1: `ack` rises in the cycle after a request only when `req` and `io_page` are both high and `addr[12:8]` equals `base_sel` or `base_sel`+1. Any other request gets no `ack` and changes no state.
- R2: The window starts at `base_sel`×256 bytes within the I/O page, so it can sit on any 256-byte boundary. Moving `base_sel` moves both the CSR half and the buffer half.
- R3: Within the window, offset bit 8 selects the half: 0 selects the CSR and 1 selects the buffer. All 128 words of the CSR half reach the same register.
- R4: A CSR write stores `wdata[15:4]` as the 12-bit page number. Later buffer accesses use the new page.
- R5: A buffer access reaches the byte address {page, `addr[7:1]`, lane}. Read data appears on `rdata` together with `ack` one cycle after the request. `rdata` is zero in every cycle without a read acknowledge.
- R6: A CSR read returns {parity flag, page[10:0], 4'b0000}.
- R7: In full capacity, `addr[7]` selects one of two distinct 128-byte banks of the buffer.
- R8: Each byte is stored with odd parity. A buffer read that finds bad parity in any byte it reads sets the flag. The flag stays set until any CSR write clears it. Reset clears the page number and the flag.
- R9: When `byte_en` is high, `addr[0]` chooses the byte lane: 1 selects the high byte on `wdata[15:8]` and 0 selects the low byte on `wdata[7:0]`. A buffer byte write changes only that byte and its parity bit. A CSR byte write changes only the page bits carried in that lane: the high lane sets page[11:4] and the low lane sets page[3:0].
- R10: With `HALF_CAP`=1, `addr[7]` is ignored and the buffer shrinks to 128 bytes, so offsets 0x00 and 0x80 reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Bus request strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| byte_en | input | 1 | 1 = byte access, lane chosen by addr[0] |
| io_page | input | 1 | High when the I/O page is being addressed |
| addr | input | 13 | Byte offset within the I/O page |
| wdata | input | 16 | Write data |
| base_sel | input | 5 | Switch setting: window start in 256-byte units |
| ack | output | 1 | Access acknowledge, one cycle after an accepted request |
| rdata | output | 16 | Read data, valid with ack on reads |

## Verification
The bench runs one fixed set of words through the buffer on several pages and both banks. This tells address formation apart from page latching. Byte writes to each lane of the buffer and of the CSR catch any lane-mixing mistake. Requests with `io_page` low, requests just above and just below the window, and a moved base address check that decode alone gates every state change. A sweep over a never-written page, followed by good reads and then a CSR write, separates the setting, holding and clearing of the parity flag. A second instance with half capacity shows that bank bit 7 folds away.

// File: rtl/rdw_pkg.sv
// Shared constants and helpers for the paged RAM disk.
// Assumes a 16-bit bus with two byte lanes and an 8 KB I/O page.
package rdw_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int PAGE_W  = 12;                 // page bits held in the CSR
    localparam int OFS_W   = 13;                 // I/O page byte offset width
    localparam int WIN_LSB = 8;                  // window granularity: 256 bytes
    localparam int BASE_W  = OFS_W - WIN_LSB;    // width of the base switch
    localparam int LOW_PG  = PAGE_W - BYTE_W;    // page bits carried by low lane

    typedef logic [LANES-1:0] lane_t;

    // Lanes touched by an access: both for a word, one for a byte.
    function automatic lane_t lanes_of(input logic is_byte, input logic a0);
        if (!is_byte) return '1;
        return a0 ? lane_t'(2'b10) : lane_t'(2'b01);
    endfunction
endpackage

// File: rtl/rdw_decode.sv
// Window decode: finds whether a request hits the CSR half or the buffer
// half of the 512-byte window placed at base_sel * 256 in the I/O page.
// Assumes base_sel is static while requests are in flight.
module rdw_decode
    import rdw_pkg::*;
(
    input  logic              req,
    input  logic              io_page,
    input  logic [BASE_W-1:0] addr_hi,
    input  logic [BASE_W-1:0] base_sel,
    output logic              csr_hit,
    output logic              buf_hit
);
    logic [BASE_W:0] diff;
    logic            in_win;

    // Offset of the request from the base in 256-byte units; a borrow lands in the top bit.
    always_comb begin
        diff    = {1'b0, addr_hi} - {1'b0, base_sel};
        in_win  = req && io_page && (diff[BASE_W:1] == '0);
        csr_hit = in_win && !diff[0];
        buf_hit = in_win && diff[0];
    end
endmodule

// File: rtl/rdw_csr.sv
// Control/status register: holds the 12-bit page number taken from write
// data bits 15..4 and the sticky parity-error flag.
// Assumes at most one of wr / rd_chk is high in a cycle.
module rdw_csr
    import rdw_pkg::*;
#(
    parameter int LO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  lane_t             lane_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rd_chk,
    input  logic              perr,
    output logic [LO_W-1:0]   page_lo,
    output logic [WORD_W-1:0] rdata
);
    localparam int PAD_W = WORD_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic              flag;

    // Page latch with per-lane update and the sticky parity flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            flag <= 1'b0;
        end else if (wr) begin
            if (lane_en[0]) page[LOW_PG-1:0] <= wdata[BYTE_W-1:PAD_W];
            if (lane_en[1]) page[PAGE_W-1:LOW_PG] <= wdata[WORD_W-1:BYTE_W];
            flag <= 1'b0;
        end else if (rd_chk && perr) begin
            flag <= 1'b1;
        end
    end

    // Readback: flag replaces the top page bit, low pad bits read as zero.
    always_comb begin
        rdata   = {flag, page[PAGE_W-2:0], {PAD_W{1'b0}}};
        page_lo = page[LO_W-1:0];
    end

    // R8: any CSR write leaves the flag clear
    a_r8_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr) |-> !flag);
    // R8: flag is sticky until a CSR write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr) |=> flag);
    // R8: flag only rises after a buffer read that failed parity
    a_r8_rise_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(rd_chk && perr));
    // R9: a high-lane write lands in the top eight page bits
    a_r9_high_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr && lane_en[1]) |-> page[PAGE_W-1:LOW_PG] == $past(wdata[WORD_W-1:BYTE_W]));
endmodule

// File: rtl/rdw_store.sv
// Byte-parity storage array: one byte plane and one odd-parity plane per
// lane, written per lane and read combinationally with a parity check.
// Assumes no reset of contents: unwritten locations hold unknown data.
module rdw_store
    import rdw_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  lane_t             lane_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              perr
);
    localparam int DEPTH = 1 << IDX_W;

    lane_t bad;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        logic              par [DEPTH];

        // Lane write: byte plus its odd-parity bit.
        always_ff @(posedge clk) begin
            if (wr && lane_en[g]) begin
                mem[idx] <= wdata[g*BYTE_W +: BYTE_W];
                par[idx] <= ~^wdata[g*BYTE_W +: BYTE_W];
            end
        end

        // Lane read and parity check: good when the nine bits hold an odd count of ones.
        always_comb begin
            rdata[g*BYTE_W +: BYTE_W] = mem[idx];
            bad[g] = ~(^{mem[idx], par[idx]});
        end
    end

    // Error only for lanes the current read actually touches.
    always_comb perr = rd && |(bad & lane_en);

    // R8: a word just written and read back at once never reports bad parity
    a_r8_fresh_word_good: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && $past(wr) && $past(lane_en) == 2'b11 && $past(idx) == idx) |-> !perr);
endmodule

// File: rtl/paged_ramdisk.sv
// Paged RAM disk bus slave: a 512-byte I/O window whose low half is the
// page/status register and whose high half views one 256-byte slice of a
// byte-parity store. Single-cycle requests, registered response.
// Assumes req is a one-cycle strobe and base_sel is static during use.
module paged_ramdisk
    import rdw_pkg::*;
#(
    parameter int STORE_PG_BITS = 3,
    parameter bit HALF_CAP      = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              byte_en,
    input  logic              io_page,
    input  logic [12:0]       addr,
    input  logic [15:0]       wdata,
    input  logic [4:0]        base_sel,
    output logic              ack,
    output logic [15:0]       rdata
);
    localparam int IDX_W = STORE_PG_BITS + 7;

    logic                     csr_hit, buf_hit;
    logic                     csr_wr, buf_wr, buf_rd;
    lane_t                    lane_en;
    logic [STORE_PG_BITS-1:0] page_lo;
    logic [WORD_W-1:0]        csr_rdata, mem_rdata;
    logic                     perr;
    logic [IDX_W-1:0]         idx;

    rdw_decode u_dec (
        .req      (req),
        .io_page  (io_page),
        .addr_hi  (addr[OFS_W-1:WIN_LSB]),
        .base_sel (base_sel),
        .csr_hit  (csr_hit),
        .buf_hit  (buf_hit)
    );

    // Access qualifiers for the register and the array.
    always_comb begin
        lane_en = lanes_of(byte_en, addr[0]);
        csr_wr  = csr_hit && we;
        buf_wr  = buf_hit && we;
        buf_rd  = buf_hit && !we;
    end

    // Word index: page bits over the in-window word offset; bank bit folds away in half capacity.
    if (HALF_CAP) begin : g_half
        always_comb idx = {page_lo, 1'b0, addr[6:1]};
    end else begin : g_full
        always_comb idx = {page_lo, addr[7:1]};
    end

    rdw_csr #(.LO_W(STORE_PG_BITS)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (csr_wr),
        .lane_en (lane_en),
        .wdata   (wdata),
        .rd_chk  (buf_rd),
        .perr    (perr),
        .page_lo (page_lo),
        .rdata   (csr_rdata)
    );

    rdw_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (buf_wr),
        .rd      (buf_rd),
        .lane_en (lane_en),
        .idx     (idx),
        .wdata   (wdata),
        .rdata   (mem_rdata),
        .perr    (perr)
    );

    // Registered response: acknowledge and read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack   <= csr_hit || buf_hit;
            rdata <= (csr_hit && !we) ? csr_rdata : (buf_rd ? mem_rdata : '0);
        end
    end

    // R1: no acknowledge without a request into the I/O page
    a_r1_ack_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(req && io_page));
    // R5: read data is quiet when nothing is acknowledged
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |-> rdata == '0);
    // R5: write acknowledges carry no data
    a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && $past(we)) |-> rdata == '0);
endmodule

// File: tb/tb_paged_ramdisk.sv
module tb_paged_ramdisk;
    localparam int PGB   = 3;
    localparam int PAGES = 1 << PGB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, byte_en = 1'b0, io_page = 1'b0;
    logic [12:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [4:0]  base_sel = 5'h12;
    logic        ack, ack_h;
    logic [15:0] rdata, rdata_h;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    paged_ramdisk #(.STORE_PG_BITS(PGB), .HALF_CAP(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .byte_en(byte_en),
        .io_page(io_page), .addr(addr), .wdata(wdata), .base_sel(base_sel),
        .ack(ack), .rdata(rdata));

    paged_ramdisk #(.STORE_PG_BITS(PGB), .HALF_CAP(1'b1)) dut_half (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .byte_en(byte_en),
        .io_page(io_page), .addr(addr), .wdata(wdata), .base_sel(base_sel),
        .ack(ack_h), .rdata(rdata_h));

    // ---------------- behavioural reference model ----------------
    bit [7:0]  mdata [int];
    bit [11:0] m_page;
    int        m_flag;          // 0 clear, 1 set, 2 unknown
    bit        exp_ack;
    bit [15:0] exp_rd, exp_mask;
    int        kind;            // 5 buffer/idle, 6 CSR read
    bit        live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_page = '0; m_flag = 0; exp_ack = 0; exp_rd = '0;
            exp_mask = 16'hFFFF; kind = 5; live = 1;
        end else begin
            int d;
            int ba;
            bit [1:0] ln;
            bit in_w;
            d = int'(addr[12:8]) - int'(base_sel);
            in_w = req && io_page && (d == 0 || d == 1);
            ln = !byte_en ? 2'b11 : (addr[0] ? 2'b10 : 2'b01);
            exp_ack = in_w; exp_rd = '0; exp_mask = 16'hFFFF; kind = 5;
            if (in_w && d == 0) begin
                if (we) begin
                    if (ln[0]) m_page[3:0]  = wdata[7:4];
                    if (ln[1]) m_page[11:4] = wdata[15:8];
                    m_flag = 0;
                end else begin
                    exp_rd = {m_flag == 1, m_page[10:0], 4'b0};
                    if (m_flag == 2) exp_mask[15] = 1'b0;
                    kind = 6;
                end
            end else if (in_w && d == 1) begin
                ba = (int'(m_page) % PAGES) * 256 + int'(addr[7]) * 128 + int'(addr[6:1]) * 2;
                for (int l = 0; l < 2; l++) begin
                    if (we) begin
                        if (ln[l]) mdata[ba + l] = wdata[l*8 +: 8];
                    end else if (mdata.exists(ba + l)) begin
                        exp_rd[l*8 +: 8] = mdata[ba + l];
                    end else begin
                        exp_mask[l*8 +: 8] = 8'h00;
                        if (ln[l] && m_flag == 0) m_flag = 2;
                    end
                end
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            checks++;
            if (ack !== exp_ack) begin
                errors++;
                $display("FAIL R1 ack actual=%0b expected=%0b", ack, exp_ack);
            end
            checks++;
            if ((rdata & exp_mask) !== (exp_rd & exp_mask)) begin
                errors++;
                $display("FAIL R%0d rdata actual=%h expected=%h mask=%h", kind, rdata, exp_rd, exp_mask);
            end
        end
    end

    // ---------------- directed stimulus ----------------
    logic [15:0] r, rh;
    logic        ak;

    task automatic bus(input logic [12:0] a, input logic w, input logic b,
                       input logic [15:0] dv, input logic io);
        @(negedge clk);
        req = 1'b1; we = w; byte_en = b; addr = a; wdata = dv; io_page = io;
        @(negedge clk);
        r = rdata; rh = rdata_h; ak = ack;
        req = 1'b0; we = 1'b0; byte_en = 1'b0; io_page = 1'b0;
    endtask

    task automatic exp16(input string tag, input logic [15:0] act, input logic [15:0] e);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    localparam logic [12:0] C = 13'h1200;
    localparam logic [12:0] B = 13'h1300;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8 reset state, R6 readback format
        bus(C, 0, 0, 0, 1); exp16("R8 reset csr", r, 16'h0000); exp16("R1 ack", {15'b0, ak}, 16'h1);
        // R4/R6 word write of the page
        bus(C, 1, 0, 16'hABC5, 1);
        bus(C, 0, 0, 0, 1); exp16("R6 csr readback", r, 16'h2BC0);
        // R3 alias inside CSR half
        bus(C + 13'h7E, 0, 0, 0, 1); exp16("R3 csr alias", r, 16'h2BC0);
        // R9 CSR byte lanes
        bus(C + 13'h1, 1, 1, 16'h5A00, 1);
        bus(C, 0, 0, 0, 1); exp16("R9 csr high lane", r, 16'h5AC0);
        bus(C, 1, 1, 16'h0030, 1);
        bus(C, 0, 0, 0, 1); exp16("R9 csr low lane", r, 16'h5A30);

        // R5/R7 buffer on page 1
        bus(C, 1, 0, 16'h0010, 1);
        bus(B + 13'h00, 1, 0, 16'h1234, 1);
        bus(B + 13'h02, 1, 0, 16'hA5C3, 1);
        bus(B + 13'h7E, 1, 0, 16'h0F0F, 1);
        bus(B + 13'h80, 1, 0, 16'h8001, 1);
        bus(B + 13'h00, 0, 0, 0, 1); exp16("R5 word 00", r, 16'h1234);
        bus(B + 13'h02, 0, 0, 0, 1); exp16("R5 word 02", r, 16'hA5C3);
        bus(B + 13'h7E, 0, 0, 0, 1); exp16("R5 word 7E", r, 16'h0F0F);
        bus(B + 13'h80, 0, 0, 0, 1); exp16("R7 bank 1", r, 16'h8001);

        // R9 buffer byte writes
        bus(B + 13'h03, 1, 1, 16'h7700, 1);
        bus(B + 13'h02, 0, 0, 0, 1); exp16("R9 buf high byte", r, 16'h77C3);
        bus(B + 13'h02, 1, 1, 16'h0011, 1);
        bus(B + 13'h02, 0, 0, 0, 1); exp16("R9 buf low byte", r, 16'h7711);

        // R4 paging
        bus(C, 1, 0, 16'h0020, 1);
        bus(B, 1, 0, 16'hCAFE, 1);
        bus(B, 0, 0, 0, 1); exp16("R4 page 2", r, 16'hCAFE);
        bus(C, 1, 0, 16'h0010, 1);
        bus(B, 0, 0, 0, 1); exp16("R4 back to page 1", r, 16'h1234);

        // R1 misses have no effect
        bus(B, 1, 0, 16'hDEAD, 0); exp16("R1 no io_page ack", {15'b0, ak}, 16'h0);
        bus(B, 0, 0, 0, 1); exp16("R1 no io_page write", r, 16'h1234);
        bus(13'h1400, 0, 0, 0, 1); exp16("R1 above window", {15'b0, ak}, 16'h0);
        bus(13'h1100, 0, 0, 0, 1); exp16("R1 below window", {15'b0, ak}, 16'h0);

        // R2 moved base
        @(negedge clk); base_sel = 5'h13;
        bus(13'h1300, 0, 0, 0, 1); exp16("R2 csr at new base", r, 16'h0010);
        bus(13'h1200, 0, 0, 0, 1); exp16("R2 old base misses", {15'b0, ak}, 16'h0);
        @(negedge clk); base_sel = 5'h12;

        // R10 half capacity folds bank bit
        bus(B + 13'h00, 1, 0, 16'h1111, 1);
        bus(B + 13'h80, 1, 0, 16'h2222, 1);
        bus(B + 13'h00, 0, 0, 0, 1);
        exp16("R10 half alias", rh, 16'h2222);
        exp16("R7 full keeps bank 0", r, 16'h1111);

        // R8 parity flag
        bus(C, 0, 0, 0, 1); exp16("R8 flag clear after good reads", r, 16'h0010);
        bus(C, 1, 0, 16'h0050, 1);
        for (int i = 0; i < 128; i++) bus(B + 13'(2 * i), 0, 0, 0, 1);
        bus(C, 0, 0, 0, 1); exp16("R8 flag set by unwritten reads", r, 16'h8050);
        bus(B, 1, 0, 16'h4444, 1);
        bus(B, 0, 0, 0, 1); exp16("R5 written word on page 5", r, 16'h4444);
        bus(C, 0, 0, 0, 1); exp16("R8 flag sticky", r, 16'h8050);
        bus(C, 1, 0, 16'h0050, 1);
        bus(C, 0, 0, 0, 1); exp16("R8 flag cleared by csr write", r, 16'h0050);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule